// File: doc/BRIEF.md
# Low-Power Start-of-Transmission Sequence Monitor

This block sits beside the receiver of one serial display data lane and watches the two synchronized low-power comparator bits that come from the lane. It checks each entry from low-power idle into high-speed operation. A legal entry goes from the stop state (both bits high) to the request state (positive bit low, negative bit high). It then goes to the bridge state (both bits low), and only after that does the high-speed indication rise. The block measures how many sample clocks the line spends low before high-speed starts.

The request and bridge samples are counted together as one contiguous low plateau. The bridge samples alone are also reported as the exit length. Each finished entry produces a one-cycle result with a pass flag. A collapsed or absent plateau raises a one-cycle flicker-suspect pulse. Saturating counters keep the number of passing, failing and incomplete entries across many sessions. The minimum plateau and minimum exit lengths are programmed in sample clocks, so the roughly 50 ns limits scale with the sample rate. A lane mask lets the same monitor be placed on a continuous-clock lane, where low-power states never occur and must not raise errors.

Top module: `lpsot_monitor`

## Requirements
- R1: During and directly after a synchronous reset, res_valid, res_pass, flicker, exit_short, plat_len, exit_len and all three counters read zero.
- R2: A measurement starts only after at least one sample with {lp_p,lp_n}=2'b11 and hs_active low. Low states or a high-speed start seen without a preceding stop sample produce no result.
- R3: A legal entry produces a one-cycle res_valid in the cycle after the edge that samples hs_active high. The legal entry is 2'b11, then N>=1 samples of 2'b01, then M>=1 samples of 2'b00, then hs_active. The result has plat_len=N+M and res_pass=1 exactly when N+M >= min_plat.
- R4: Order violations produce a result with res_pass=0. If hs_active rises from the stop or request state, the result has plat_len equal to the request samples seen and exit_len=0. A 2'b00 sample directly after the stop state fails at once with plat_len=0.
- R5: flicker pulses together with res_valid exactly when the reported plat_len is below min_plat.
- R6: exit_len reports the number of 2'b00 samples before high-speed. exit_short is set with the result when exit_len < min_exit.
- R7: If win_end is sampled high while a measurement is armed or running, no result is produced and the incomplete counter increments.
- R8: The pass, fail and incomplete counters each increment once per matching event, hold at all-ones, and return to zero on the edge after clr is high.
- R9: While lane_mask is high, no result is produced, no counter changes, and any measurement in progress is dropped. A new stop sample is then needed.
- R10: plat_len and exit_len saturate at 2**LW-1 on long plateaus.
- R11: A return to 2'b11 in the middle of an entry drops it without a result and re-arms. A 2'b10 sample drops it and disarms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the event counters |
| lp_p | input | 1 | Synchronized positive low-power comparator bit |
| lp_n | input | 1 | Synchronized negative low-power comparator bit |
| hs_active | input | 1 | High-speed reception has started |
| win_end | input | 1 | Observation window closed |
| lane_mask | input | 1 | Ignore the lane (continuous-clock use) |
| min_plat | input | LW | Minimum low plateau in sample clocks |
| min_exit | input | LW | Minimum bridge-state length in sample clocks |
| plat_len | output | LW | Last measured low plateau length |
| exit_len | output | LW | Last measured bridge-state length |
| res_valid | output | 1 | One-cycle pulse: a new result is present |
| res_pass | output | 1 | Last entry was legal and long enough |
| exit_short | output | 1 | Last exit length was below min_exit |
| flicker | output | 1 | One-cycle flicker-suspect pulse |
| pass_cnt | output | NW | Saturating count of passing entries |
| fail_cnt | output | NW | Saturating count of failing entries |
| inc_cnt | output | NW | Saturating count of incomplete entries |

## Verification
The bench builds the monitor with LW=6 and NW=3, using a minimum plateau of 5 and a minimum exit of 2 samples. The three-bit counters saturate after seven events. This lets a full sweep of request lengths 0..4 against bridge lengths 0..4 reach counter saturation. The same sweep lands on both sides of the plateau and exit limits and covers every skipped-state case. With the six-bit lengths, a 73-sample plateau exercises length saturation in a few dozen cycles. Separate runs cover the unarmed start, mid-entry aborts, window-end incompletes and masking.

// File: rtl/lpsot_pkg.sv
package lpsot_pkg;

    // Encoding is {lp_p, lp_n}
    typedef enum logic [1:0] {
        LS_BRIDGE00 = 2'b00,
        LS_REQ01    = 2'b01,
        LS_ESC10    = 2'b10,
        LS_STOP11   = 2'b11
    } lp_state_e;

    typedef enum logic [1:0] {
        ST_UNARMED,
        ST_ARMED,
        ST_REQ,
        ST_BRIDGE
    } mon_state_e;

    typedef struct packed {
        logic fin;      // entry finished with a verdict
        logic order_ok; // full stop-request-bridge-hs order observed
        logic incmp;    // entry cut by window end
    } step_ev_t;

    function automatic logic is_low_state(lp_state_e s);
        return (s == LS_REQ01) || (s == LS_BRIDGE00);
    endfunction

endpackage

// File: rtl/lpsot_decode.sv
module lpsot_decode
    import lpsot_pkg::*;
(
    input  logic      lp_p,
    input  logic      lp_n,
    output lp_state_e lane
);
    assign lane = lp_state_e'({lp_p, lp_n});
endmodule

// File: rtl/lpsot_fsm.sv
module lpsot_fsm
    import lpsot_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  lp_state_e     lane,
    input  logic          hs_active,
    input  logic          win_end,
    input  logic          lane_mask,
    input  logic [LW-1:0] min_plat,
    input  logic [LW-1:0] min_exit,
    output logic [LW-1:0] plat_len,
    output logic [LW-1:0] exit_len,
    output logic          res_valid,
    output logic          res_pass,
    output logic          exit_short,
    output logic          flicker,
    output logic          incmp_pulse
);
    localparam logic [LW-1:0] LMAX = '1;
    localparam logic [LW-1:0] ONE  = 1;

    mon_state_e    state_q, state_d;
    logic [LW-1:0] plat_q, plat_d, exit_q, exit_d;
    step_ev_t      ev;

    function automatic logic [LW-1:0] bump(logic [LW-1:0] v);
        return (v == LMAX) ? v : v + ONE;
    endfunction

    always_comb begin
        state_d = state_q;
        plat_d  = plat_q;
        exit_d  = exit_q;
        ev      = '0;
        if (lane_mask) begin
            state_d = ST_UNARMED;
        end else begin
            case (state_q)
                ST_UNARMED: begin
                    if (!hs_active && lane == LS_STOP11) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (win_end) begin
                        ev.incmp = 1'b1;
                        state_d  = ST_UNARMED;
                    end else if (hs_active) begin
                        ev.fin  = 1'b1;
                        state_d = ST_UNARMED;
                    end else begin
                        case (lane)
                            LS_REQ01: begin
                                state_d = ST_REQ;
                                plat_d  = ONE;
                            end
                            LS_BRIDGE00: begin
                                ev.fin  = 1'b1;
                                state_d = ST_UNARMED;
                            end
                            LS_ESC10: state_d = ST_UNARMED;
                            default:  state_d = ST_ARMED;
                        endcase
                    end
                end
                ST_REQ: begin
                    if (win_end) begin
                        ev.incmp = 1'b1;
                        state_d  = ST_UNARMED;
                    end else if (hs_active) begin
                        ev.fin  = 1'b1;
                        state_d = ST_UNARMED;
                    end else begin
                        case (lane)
                            LS_REQ01: plat_d = bump(plat_q);
                            LS_BRIDGE00: begin
                                state_d = ST_BRIDGE;
                                plat_d  = bump(plat_q);
                                exit_d  = ONE;
                            end
                            LS_STOP11: state_d = ST_ARMED;
                            default:   state_d = ST_UNARMED;
                        endcase
                    end
                end
                default: begin
                    if (win_end) begin
                        ev.incmp = 1'b1;
                        state_d  = ST_UNARMED;
                    end else if (hs_active) begin
                        ev.fin      = 1'b1;
                        ev.order_ok = 1'b1;
                        state_d     = ST_UNARMED;
                    end else begin
                        case (lane)
                            LS_BRIDGE00: begin
                                plat_d = bump(plat_q);
                                exit_d = bump(exit_q);
                            end
                            LS_STOP11: state_d = ST_ARMED;
                            default:   state_d = ST_UNARMED;
                        endcase
                    end
                end
            endcase
        end
        if (!is_low_state(lane_state_for(state_d))) begin
            plat_d = '0;
            exit_d = '0;
        end
    end

    // Maps a monitor state to whether its length registers are live
    function automatic lp_state_e lane_state_for(mon_state_e s);
        return (s == ST_REQ || s == ST_BRIDGE) ? LS_REQ01 : LS_STOP11;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_UNARMED;
            plat_q      <= '0;
            exit_q      <= '0;
            plat_len    <= '0;
            exit_len    <= '0;
            res_valid   <= 1'b0;
            res_pass    <= 1'b0;
            exit_short  <= 1'b0;
            flicker     <= 1'b0;
            incmp_pulse <= 1'b0;
        end else begin
            state_q     <= state_d;
            plat_q      <= plat_d;
            exit_q      <= exit_d;
            res_valid   <= ev.fin;
            flicker     <= ev.fin && (plat_q < min_plat);
            incmp_pulse <= ev.incmp;
            if (ev.fin) begin
                plat_len   <= plat_q;
                exit_len   <= exit_q;
                res_pass   <= ev.order_ok && (plat_q >= min_plat);
                exit_short <= exit_q < min_exit;
            end
        end
    end

    // R2
    armed_first_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(state_q) != ST_UNARMED));

    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lane_mask) |-> (!res_valid && !incmp_pulse));

    // R5
    flicker_short_chk: assert property (@(posedge clk) disable iff (rst)
        flicker |-> (res_valid && !res_pass && plat_len < $past(min_plat)));

    // R3
    pass_len_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pass) |-> (plat_len >= $past(min_plat) && exit_len != '0
                                     && plat_len > exit_len));

    // R6
    exit_within_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (exit_len <= plat_len));

    // R7
    incmp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(incmp_pulse && res_valid));

endmodule

// File: rtl/lpsot_stats.sv
module lpsot_stats #(
    parameter int NW = 16,
    parameter int NC = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [NC-1:0]        hit,
    output logic [NC-1:0][NW-1:0] cnt
);
    localparam logic [NW-1:0] CMAX = '1;
    localparam logic [NW-1:0] ONE  = 1;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (rst || clr)
                cnt[i] <= '0;
            else if (hit[i] && cnt[i] != CMAX)
                cnt[i] <= cnt[i] + ONE;
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_chk
        // R8
        no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (cnt[g] >= $past(cnt[g])));
        // R8
        clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
            clr |=> (cnt[g] == '0));
        // R8
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr && !hit[g]) |=> $stable(cnt[g]));
    end

endmodule

// File: rtl/lpsot_monitor.sv
module lpsot_monitor
    import lpsot_pkg::*;
#(
    parameter int LW = 8,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          lp_p,
    input  logic          lp_n,
    input  logic          hs_active,
    input  logic          win_end,
    input  logic          lane_mask,
    input  logic [LW-1:0] min_plat,
    input  logic [LW-1:0] min_exit,
    output logic [LW-1:0] plat_len,
    output logic [LW-1:0] exit_len,
    output logic          res_valid,
    output logic          res_pass,
    output logic          exit_short,
    output logic          flicker,
    output logic [NW-1:0] pass_cnt,
    output logic [NW-1:0] fail_cnt,
    output logic [NW-1:0] inc_cnt
);
    localparam int NCNT = 3;

    lp_state_e             lane;
    logic                  incmp_pulse;
    logic [NCNT-1:0]       hits;
    logic [NCNT-1:0][NW-1:0] cnts;

    lpsot_decode dec_i (
        .lp_p (lp_p),
        .lp_n (lp_n),
        .lane (lane)
    );

    lpsot_fsm #(.LW(LW)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .lane        (lane),
        .hs_active   (hs_active),
        .win_end     (win_end),
        .lane_mask   (lane_mask),
        .min_plat    (min_plat),
        .min_exit    (min_exit),
        .plat_len    (plat_len),
        .exit_len    (exit_len),
        .res_valid   (res_valid),
        .res_pass    (res_pass),
        .exit_short  (exit_short),
        .flicker     (flicker),
        .incmp_pulse (incmp_pulse)
    );

    assign hits = {incmp_pulse, res_valid && !res_pass, res_valid && res_pass};

    lpsot_stats #(.NW(NW), .NC(NCNT)) stats_i (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .hit (hits),
        .cnt (cnts)
    );

    assign pass_cnt = cnts[0];
    assign fail_cnt = cnts[1];
    assign inc_cnt  = cnts[2];

endmodule

// File: tb/lpsot_monitor_tb_top.sv
module lpsot_monitor_tb_top;
    localparam int LW = 6;
    localparam int NW = 3;
    localparam int MINP = 5;
    localparam int MINX = 2;
    localparam int CSAT = 7;
    localparam int LSAT = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic lp_p = 1'b0, lp_n = 1'b0, hs_active = 1'b0, win_end = 1'b0, lane_mask = 1'b0;
    logic [LW-1:0] min_plat = LW'(MINP);
    logic [LW-1:0] min_exit = LW'(MINX);
    logic [LW-1:0] plat_len, exit_len;
    logic res_valid, res_pass, exit_short, flicker;
    logic [NW-1:0] pass_cnt, fail_cnt, inc_cnt;

    always #4 clk = ~clk;

    lpsot_monitor #(.LW(LW), .NW(NW)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .lp_p(lp_p), .lp_n(lp_n),
        .hs_active(hs_active), .win_end(win_end), .lane_mask(lane_mask),
        .min_plat(min_plat), .min_exit(min_exit), .plat_len(plat_len),
        .exit_len(exit_len), .res_valid(res_valid), .res_pass(res_pass),
        .exit_short(exit_short), .flicker(flicker), .pass_cnt(pass_cnt),
        .fail_cnt(fail_cnt), .inc_cnt(inc_cnt)
    );

    int errors = 0;
    int checks = 0;
    int seen = 0;
    int flk_seen = 0;
    int c_plat = 0, c_exit = 0, c_pass = 0, c_es = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        #2;
        if (!rst && res_valid) begin
            seen++;
            c_plat = int'(plat_len);
            c_exit = int'(exit_len);
            c_pass = int'(res_pass);
            c_es   = int'(exit_short);
        end
        if (!rst && flicker) flk_seen++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic n, input logic hs, input logic we);
        @(negedge clk);
        lp_p = p; lp_n = n; hs_active = hs; win_end = we;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic entry(input int n, input int m);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < m; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        idle(2);
    endtask

    function automatic int smin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        int e_pass = 0, e_fail = 0, e_inc = 0;
        int s0, f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 plat_len", int'(plat_len), 0);
        chk("R1 counters", int'(pass_cnt) + int'(fail_cnt) + int'(inc_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(res_valid) + int'(flicker) + int'(res_pass) + int'(exit_short), 0);

        // R2 no stop sample first: low states and hs produce nothing
        s0 = seen;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R2 unarmed no result", seen - s0, 0);
        chk("R2 unarmed no count", int'(pass_cnt) + int'(fail_cnt), 0);

        // R3 R4 R5 R6 R8 sweep of request and bridge lengths
        for (int n = 0; n <= 4; n++) begin
            for (int m = 0; m <= 4; m++) begin
                int ep, ex, eok;
                s0 = seen; f0 = flk_seen;
                entry(n, m);
                if (n == 0 && m > 0) begin ep = 0; ex = 0; eok = 0; end
                else if (m == 0) begin ep = n; ex = 0; eok = 0; end
                else begin ep = n + m; ex = m; eok = (n + m >= MINP) ? 1 : 0; end
                if (eok != 0) e_pass++; else e_fail++;
                chk("R3 one result", seen - s0, 1);
                chk((m > 0 && n > 0) ? "R3 plat_len" : "R4 plat_len", c_plat, ep);
                chk((m > 0 && n > 0) ? "R3 pass" : "R4 fail", c_pass, eok);
                chk("R6 exit_len", c_exit, ex);
                chk("R6 exit_short", c_es, (ex < MINX) ? 1 : 0);
                chk("R5 flicker", flk_seen - f0, (ep < MINP) ? 1 : 0);
                chk("R8 pass_cnt", int'(pass_cnt), smin(e_pass, CSAT));
                chk("R8 fail_cnt", int'(fail_cnt), smin(e_fail, CSAT));
            end
        end

        // R8 clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R8 clear", int'(pass_cnt) + int'(fail_cnt) + int'(inc_cnt), 0);

        // R11 return to stop mid-entry re-arms; escape state disarms
        s0 = seen;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R11 rearm single result", seen - s0, 1);
        chk("R11 rearm plat_len", c_plat, 6);
        chk("R11 rearm pass", c_pass, 1);
        s0 = seen;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R11 escape drops entry", seen - s0, 0);

        // R10 length saturation
        s0 = seen;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R10 result", seen - s0, 1);
        chk("R10 plat_len saturates", c_plat, LSAT);
        chk("R10 exit_len", c_exit, 3);

        // R7 window end gives incomplete, counter saturates
        s0 = seen;
        for (int k = 1; k <= 9; k++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            for (int i = 0; i < k % 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b1, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b1, 1'b0);
            idle(2);
            e_inc++;
            chk("R7 inc_cnt", int'(inc_cnt), smin(e_inc, CSAT));
        end
        chk("R7 no result on window end", seen - s0, 0);

        // R9 mask: no result and counters unchanged
        s0 = seen;
        lane_mask = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b1);
        idle(3);
        lane_mask = 1'b0;
        chk("R9 masked no result", seen - s0, 0);
        chk("R9 masked inc_cnt", int'(inc_cnt), CSAT);
        chk("R9 masked pass_cnt", int'(pass_cnt), 2);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk); lane_mask = 1'b1;
        @(negedge clk); lane_mask = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R9 mask drops entry", seen - s0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule